// File: doc/BRIEF.md
# Programmable-Format Serial Character Receiver

This block turns an asynchronous serial line back into parallel characters. The line is oversampled with a single-cycle tick that runs at sixteen times the bit rate. The receiver finds the leading edge of a start bit and confirms it half a bit later. It then samples each following bit once, at its centre, and checks the optional parity bit and the first stop bit. The character format comes from the same control fields that drive the matching transmitter: word length, parity on or off, parity sense, and parity held at a fixed level. It is captured when a start bit is accepted, so a format change takes effect from the next character.

Each character produces a one-clock strobe. The data byte and three status flags (parity error, framing error, break) are updated on the strobe and keep their values until the next character. Data bits beyond the programmed word length read as zero.

Top module: `serial_char_receiver`

## Requirements
- R1: The length field selects the number of data bits: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Bits arrive least significant first into `rx_data[0]` upward. Bits of `rx_data` at and above the word length are 0.
- R2: When `par_on` is 0, no parity bit is taken from the line and `rx_par_err` is 0 on every strobe.
- R3: When `par_on` is 1 and `par_fixed` is 0, `par_even` = 0 demands an odd count of ones over the data and parity bits, and `par_even` = 1 demands an even count. A violation sets `rx_par_err`.
- R4: When `par_on` is 1 and `par_fixed` is 1, `par_even` = 0 demands a parity bit of 1 and `par_even` = 1 demands a parity bit of 0. Any other value sets `rx_par_err`.
- R5: A low level on the line starts a character only if the line is still low eight ticks after the low level was first seen. A shorter low pulse produces no strobe, and the receiver goes back to waiting for an edge.
- R6: Only the first stop bit is sampled, whatever stop length the far end uses. A 0 there sets `rx_frm_err`. After a stop bit of 0, the receiver waits for the line to go high before it looks for a new start bit.
- R7: When every data, parity and stop sample of a character is 0, `rx_brk` is set. `rx_frm_err` is set as well. While the line stays low after that, no further strobe appears.
- R8: `rx_valid` is high for exactly one clock per character. `rx_data` and all flags are valid in that clock and hold their values until the next strobe.
- R9: While reset is active and after it is released, `rx_valid`, `rx_data`, `rx_par_err`, `rx_frm_err` and `rx_brk` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| tick16 | input | 1 | One-clock strobe at sixteen times the bit rate |
| fmt_len | input | 2 | Word length code (5 to 8 bits) |
| par_on | input | 1 | Parity bit present and checked |
| par_even | input | 1 | Parity sense select |
| par_fixed | input | 1 | Parity held at a fixed level |
| rx_data | output | 8 | Received character, zero-extended |
| rx_valid | output | 1 | One-clock character strobe |
| rx_par_err | output | 1 | Parity check failed |
| rx_frm_err | output | 1 | First stop bit was 0 |
| rx_brk | output | 1 | Whole character was held at 0 |

## Verification
The hard cases are those in which the line stays low past the stop-bit sample: a framing error followed by a low tail, and a break held low for several bit times. In both, a receiver that went straight back to hunting for an edge would take the low level as a new start bit. The driver holds the line low well beyond the stop sample and then releases it. The monitor reports any strobe that arrives while its queue of expected characters is empty. The check of the fixed-level parity modes uses a corrupted parity bit. A corrupted bit passes odd/even checking for some data values, so the two parity rules give different answers on it.

// File: rtl/srx_pkg.sv
package srx_pkg;

   localparam int unsigned CHAR_MAX = 8;
   localparam int unsigned LEN_W    = 2;
   localparam int unsigned LEN_BASE = 5;
   localparam int unsigned IDX_W    = $clog2(CHAR_MAX);

   typedef struct packed {
      logic [LEN_W-1:0] len;
      logic             par_on;
      logic             par_even;
      logic             par_fixed;
   } fmt_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_HOLD
   } rx_state_e;

   typedef struct packed {
      logic [CHAR_MAX-1:0] data;
      logic                par_err;
      logic                frm_err;
      logic                brk;
   } rx_result_t;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int unsigned STAGES     = 2,
   parameter logic        IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("srx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= IDLE_LEVEL;
            else        chain[i] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= IDLE_LEVEL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/srx_parity_eval.sv
module srx_parity_eval #(
   parameter int unsigned WIDTH = srx_pkg::CHAR_MAX
) (
   input  logic [WIDTH-1:0] data,
   input  logic             par_bit,
   input  logic             par_even,
   input  logic             par_fixed,
   output logic             par_err
);

   if (WIDTH < 1) begin : g_bad_width
      $error("srx_parity_eval: WIDTH must be positive");
   end

   // running xor across the data bits; unused upper bits arrive as zero
   logic [WIDTH:0] chain;
   assign chain[0] = par_bit;
   for (genvar i = 0; i < WIDTH; i++) begin : g_xor
      assign chain[i+1] = chain[i] ^ data[i];
   end

   logic ones_odd;
   logic err_count;
   logic err_level;

   always_comb begin
      ones_odd  = chain[WIDTH];
      // odd sense wants an odd total, even sense wants an even total
      err_count = par_even ? ones_odd : ~ones_odd;
      // fixed level: sense 0 wants a 1, sense 1 wants a 0
      err_level = (par_bit == par_even);
      par_err   = par_fixed ? err_level : err_count;
   end

endmodule

// File: rtl/srx_engine.sv
module srx_engine
   import srx_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_s,
   input  logic                tick,
   input  fmt_t                fmt_in,
   input  logic                par_err_in,
   output logic [CHAR_MAX-1:0] shreg_o,
   output logic                par_bit_o,
   output fmt_t                fmt_q_o,
   output rx_result_t          result_o,
   output logic                valid_o
);

   localparam int unsigned CNT_W = $clog2(OVERSAMPLE);
   localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVERSAMPLE / 2 - 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);

   rx_state_e           state;
   logic [CNT_W-1:0]    cnt;
   logic [IDX_W-1:0]    bit_idx;
   logic [CHAR_MAX-1:0] shreg;
   logic                par_bit;
   logic                all_zero;
   fmt_t                fmt_q;
   rx_result_t          result;
   logic                valid_q;
   logic [IDX_W-1:0]    last_idx;
   logic                bit_due;

   assign last_idx = IDX_W'(LEN_BASE - 1) + IDX_W'(fmt_q.len);
   assign bit_due  = tick && (cnt == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         bit_idx  <= '0;
         shreg    <= '0;
         par_bit  <= 1'b0;
         all_zero <= 1'b0;
         fmt_q    <= '0;
         result   <= '0;
         valid_q  <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (tick && state != ST_IDLE && state != ST_HOLD) begin
            cnt <= bit_due ? '0 : cnt + 1'b1;
         end
         unique case (state)
            ST_IDLE: begin
               if (tick && !rx_s) begin
                  state    <= ST_START;
                  cnt      <= '0;
                  bit_idx  <= '0;
                  shreg    <= '0;
                  par_bit  <= 1'b0;
                  all_zero <= 1'b1;
                  fmt_q    <= fmt_in;
               end
            end
            ST_START: begin
               if (tick && cnt == CNT_MID) begin
                  cnt   <= '0;
                  state <= rx_s ? ST_IDLE : ST_DATA;
               end
            end
            ST_DATA: begin
               if (bit_due) begin
                  shreg[bit_idx] <= rx_s;
                  all_zero       <= all_zero & ~rx_s;
                  if (bit_idx == last_idx) begin
                     state <= fmt_q.par_on ? ST_PAR : ST_STOP;
                  end else begin
                     bit_idx <= bit_idx + 1'b1;
                  end
               end
            end
            ST_PAR: begin
               if (bit_due) begin
                  par_bit  <= rx_s;
                  all_zero <= all_zero & ~rx_s;
                  state    <= ST_STOP;
               end
            end
            ST_STOP: begin
               if (bit_due) begin
                  valid_q         <= 1'b1;
                  result.data     <= shreg;
                  result.par_err  <= fmt_q.par_on & par_err_in;
                  result.frm_err  <= ~rx_s;
                  result.brk      <= all_zero & ~rx_s;
                  state           <= rx_s ? ST_IDLE : ST_HOLD;
               end
            end
            ST_HOLD: begin
               if (rx_s) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign shreg_o   = shreg;
   assign par_bit_o = par_bit;
   assign fmt_q_o   = fmt_q;
   assign result_o  = result;
   assign valid_o   = valid_q;

endmodule

// File: rtl/serial_char_receiver.sv
module serial_char_receiver
   import srx_pkg::*;
#(
   parameter int unsigned OVERSAMPLE  = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rxd,
   input  logic                 tick16,
   input  logic [LEN_W-1:0]     fmt_len,
   input  logic                 par_on,
   input  logic                 par_even,
   input  logic                 par_fixed,
   output logic [CHAR_MAX-1:0]  rx_data,
   output logic                 rx_valid,
   output logic                 rx_par_err,
   output logic                 rx_frm_err,
   output logic                 rx_brk
);

   if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
      $error("serial_char_receiver: OVERSAMPLE must be even and at least 4");
   end
   if (LEN_BASE + (1 << LEN_W) - 1 != CHAR_MAX) begin : g_bad_len
      $error("serial_char_receiver: length codes must span up to CHAR_MAX");
   end

   logic                rx_s;
   fmt_t                fmt_in;
   fmt_t                fmt_q;
   logic [CHAR_MAX-1:0] shreg;
   logic                par_bit;
   logic                par_err_c;
   rx_result_t          result;
   logic                valid;
   logic [LEN_W-1:0]    cur_len;
   logic                cur_par_on;

   assign fmt_in = '{len: fmt_len, par_on: par_on, par_even: par_even,
                     par_fixed: par_fixed};

   srx_sync #(
      .STAGES     (SYNC_STAGES),
      .IDLE_LEVEL (1'b1)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rxd),
      .dout (rx_s)
   );

   srx_engine #(
      .OVERSAMPLE(OVERSAMPLE)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_s      (rx_s),
      .tick      (tick16),
      .fmt_in    (fmt_in),
      .par_err_in(par_err_c),
      .shreg_o   (shreg),
      .par_bit_o (par_bit),
      .fmt_q_o   (fmt_q),
      .result_o  (result),
      .valid_o   (valid)
   );

   srx_parity_eval #(
      .WIDTH(CHAR_MAX)
   ) u_parity (
      .data     (shreg),
      .par_bit  (par_bit),
      .par_even (fmt_q.par_even),
      .par_fixed(fmt_q.par_fixed),
      .par_err  (par_err_c)
   );

   assign cur_len    = fmt_q.len;
   assign cur_par_on = fmt_q.par_on;

   assign rx_data    = result.data;
   assign rx_par_err = result.par_err;
   assign rx_frm_err = result.frm_err;
   assign rx_brk     = result.brk;
   assign rx_valid   = valid;

endmodule

// File: rtl/srx_chk.sv
module srx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_valid,
   input logic [7:0] rx_data,
   input logic       rx_par_err,
   input logic       rx_frm_err,
   input logic       rx_brk,
   input logic [1:0] cur_len,
   input logic       cur_par_on
);

   AST_VALID_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);  // R8

   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> $stable({rx_data, rx_par_err, rx_frm_err, rx_brk}));  // R8

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> ((rx_data >> (4'd5 + {2'b00, cur_len})) == 8'd0));  // R1

   AST_NOPAR_NOERR: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !cur_par_on) |-> !rx_par_err);  // R2

   AST_BRK_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_brk) |-> (rx_frm_err && rx_data == 8'd0));  // R7

endmodule

bind serial_char_receiver srx_chk u_srx_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_valid  (rx_valid),
   .rx_data   (rx_data),
   .rx_par_err(rx_par_err),
   .rx_frm_err(rx_frm_err),
   .rx_brk    (rx_brk),
   .cur_len   (cur_len),
   .cur_par_on(cur_par_on)
);

// File: tb/serial_char_receiver_test.sv
`timescale 1ns/1ps
module serial_char_receiver_test;

   localparam int TICK_DIV = 4;
   localparam int BITCLK   = 16 * TICK_DIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd = 1'b1;
   logic       tick16 = 1'b0;
   logic [1:0] fmt_len = 2'b11;
   logic       par_on = 1'b0;
   logic       par_even = 1'b0;
   logic       par_fixed = 1'b0;
   logic [7:0] rx_data;
   logic       rx_valid;
   logic       rx_par_err;
   logic       rx_frm_err;
   logic       rx_brk;

   typedef struct {
      logic [7:0] data;
      logic       pe;
      logic       fe;
      logic       brk;
      string      req;
   } exp_t;

   exp_t q[$];
   exp_t last_exp;
   int   checks = 0;
   int   errors = 0;
   int   strobes = 0;
   bit   done = 0;
   logic prev_valid = 1'b0;

   always #2 clk = ~clk;

   serial_char_receiver uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .rxd       (rxd),
      .tick16    (tick16),
      .fmt_len   (fmt_len),
      .par_on    (par_on),
      .par_even  (par_even),
      .par_fixed (par_fixed),
      .rx_data   (rx_data),
      .rx_valid  (rx_valid),
      .rx_par_err(rx_par_err),
      .rx_frm_err(rx_frm_err),
      .rx_brk    (rx_brk)
   );

   // tick generator
   int tdiv = 0;
   always @(posedge clk) begin
      tdiv   <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
      tick16 <= (tdiv == TICK_DIV - 1);
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_valid && prev_valid) begin
            checks++; errors++;
            $display("FAIL R8 strobe longer than one clock: actual 2+ cycles expected 1");
         end
         if (rx_valid) begin
            strobes++;
            checks++;
            if (q.size() == 0) begin
               errors++;
               $display("FAIL R5/R6/R7 unexpected strobe: actual data %h expected none", rx_data);
            end else begin
               exp_t e;
               e = q.pop_front();
               last_exp = e;
               if (rx_data !== e.data || rx_par_err !== e.pe ||
                   rx_frm_err !== e.fe || rx_brk !== e.brk) begin
                  errors++;
                  $display("FAIL %s actual d=%h pe=%b fe=%b brk=%b expected d=%h pe=%b fe=%b brk=%b",
                           e.req, rx_data, rx_par_err, rx_frm_err, rx_brk,
                           e.data, e.pe, e.fe, e.brk);
               end
            end
         end
         prev_valid <= rx_valid;
      end
   end

   task automatic bit_out(input logic v);
      rxd = v;
      repeat (BITCLK) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string msg, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", msg, act, exp);
      end
   endtask

   task automatic send_char(input logic [7:0] d, input logic [1:0] len,
                            input logic pen, input logic ev, input logic fix,
                            input bit flip, input logic stop_v,
                            input int stops, input string req);
      int         n;
      logic [7:0] dm;
      logic       good_p;
      logic       sent_p;
      exp_t       e;
      n  = 5 + len;
      dm = d & 8'((9'h1 << n) - 1);
      if (fix)      good_p = ~ev;
      else if (ev)  good_p = ^dm;
      else          good_p = ~(^dm);
      sent_p = good_p ^ flip;
      fmt_len = len; par_on = pen; par_even = ev; par_fixed = fix;
      e.data = dm;
      e.pe   = pen & flip;
      e.fe   = ~stop_v;
      e.brk  = (dm == 8'd0) && (!pen || !sent_p) && !stop_v;
      e.req  = req;
      q.push_back(e);
      bit_out(1'b0);
      for (int i = 0; i < n; i++) bit_out(dm[i]);
      if (pen) bit_out(sent_p);
      bit_out(stop_v);
      for (int i = 1; i < stops; i++) bit_out(1'b1);
      rxd = 1'b1;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : driver
      int s0;
      repeat (5) @(negedge clk);
      // R9: outputs cleared in and after reset
      check(rx_valid === 0 && rx_data === 0 && rx_par_err === 0 &&
            rx_frm_err === 0 && rx_brk === 0, "R9 reset state", rx_data, 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      check(rx_valid === 0 && rx_data === 0 && rx_brk === 0, "R9 after release", rx_data, 0);

      // R1 lengths, no parity
      send_char(8'hA5, 2'b11, 0, 0, 0, 0, 1, 1, "R1 8-bit");
      send_char(8'hFB, 2'b00, 0, 0, 0, 0, 1, 1, "R1 5-bit upper zero");
      send_char(8'h6E, 2'b01, 0, 0, 0, 0, 1, 1, "R1 6-bit");
      // R2 parity off, two stop bits (R6 first stop only)
      send_char(8'h37, 2'b10, 0, 1, 1, 0, 1, 2, "R2 no parity two stops");
      // R3 odd/even
      send_char(8'h2C, 2'b01, 1, 0, 0, 0, 1, 1, "R3 odd ok");
      send_char(8'h55, 2'b10, 1, 1, 0, 0, 1, 1, "R3 even ok");
      send_char(8'h55, 2'b10, 1, 1, 0, 1, 1, 1, "R3 even bad");
      send_char(8'hC3, 2'b11, 1, 0, 0, 1, 1, 1, "R3 odd bad");
      // R4 fixed level
      send_char(8'h3A, 2'b01, 1, 0, 1, 0, 1, 1, "R4 mark ok");
      send_char(8'h81, 2'b11, 1, 1, 1, 0, 1, 1, "R4 space ok");
      send_char(8'h07, 2'b00, 1, 0, 1, 1, 1, 1, "R4 mark bad");
      send_char(8'hFF, 2'b11, 1, 1, 1, 1, 1, 1, "R4 space bad");
      // R6 framing error with low tail
      send_char(8'h3C, 2'b11, 0, 0, 0, 0, 0, 1, "R6 framing");
      s0 = strobes;
      rxd = 1'b0;
      repeat (BITCLK) @(negedge clk);
      rxd = 1'b1;
      repeat (BITCLK) @(negedge clk);
      check(strobes == s0, "R6 no restart in low tail", strobes - s0, 0);
      // R7 break held low
      send_char(8'h00, 2'b11, 0, 0, 0, 0, 0, 1, "R7 break");
      s0 = strobes;
      rxd = 1'b0;
      repeat (3 * BITCLK) @(negedge clk);
      rxd = 1'b1;
      repeat (BITCLK) @(negedge clk);
      check(strobes == s0, "R7 quiet while held", strobes - s0, 0);
      // R7 break with parity
      send_char(8'h00, 2'b10, 1, 1, 0, 0, 0, 1, "R7 break with parity");
      rxd = 1'b1;
      repeat (BITCLK) @(negedge clk);
      // R5 glitch
      s0 = strobes;
      rxd = 1'b0;
      repeat (3 * TICK_DIV) @(negedge clk);
      rxd = 1'b1;
      repeat (2 * BITCLK) @(negedge clk);
      check(strobes == s0, "R5 glitch ignored", strobes - s0, 0);
      send_char(8'h5A, 2'b11, 0, 0, 0, 0, 1, 1, "R5 recovery");
      repeat (2 * BITCLK) @(negedge clk);
      // R8 held values, all delivered
      check(q.size() == 0, "R8 all characters delivered", q.size(), 0);
      check(rx_data === last_exp.data && rx_frm_err === last_exp.fe,
            "R8 result held", rx_data, last_exp.data);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule